// File: doc/BRIEF.md
# Mask-Steered Byte Shuffle Unit

This unit performs two operations on 64-bit operands. The mask operation adds two integer operands and returns the 64-bit sum. It also keeps the low 32 bits of that sum as a shuffle mask in the upper half of a 64-bit status register. The shuffle operation builds a 64-bit result from the sixteen bytes of two source operands. Each output byte is picked by one 4-bit selector taken from the stored mask.

Operations enter through a valid strobe, a 9-bit operation code and two operands. Results come out through a two-stage pipeline with a one-cycle result-valid pulse. The status register is written one cycle after the mask result leaves the pipeline. A shuffle issued in the cycle right after a mask must still see that new mask, so the pending mask is forwarded straight into the byte selection. This lets software set a mask and use it in the very next cycle.

Top module: `byte_steer_unit`

## Requirements
- R1: Opcode 9'h019 selects the mask operation and 9'h04C selects the shuffle operation. An accepted operation (op_valid high at a rising edge) produces res_valid high for exactly one cycle, after the second rising edge following the issue edge.
- R2: The mask operation returns res_data equal to opnd_a + opnd_b modulo 2^64.
- R3: The mask operation writes sum[31:0] into status_q[63:32] at the rising edge after its res_valid cycle. It leaves status_q[31:0] unchanged.
- R4: For output lane i (0 to 7), the selector is the mask nibble at bits [4i+3:4i], and the chosen byte lands in res_data[8i+7:8i].
- R5: A selector value s from 0 to 7 picks byte s of opnd_a, counting from the least significant byte.
- R6: A selector value s from 8 to 15 picks byte s-8 of opnd_b.
- R7: A shuffle issued in the cycle after a mask uses that mask, before the status register holds it. After two back-to-back masks, a following shuffle uses the younger mask.
- R8: A shuffle issued after the status register has been written uses the stored mask, and the shuffle leaves status_q unchanged.
- R9: An operation with op_valid low, or with any opcode other than the two in R1, produces no res_valid pulse and leaves status_q unchanged.
- R10: While rst_n is low, status_q, res_data and res_valid are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 9 | Operation code |
| opnd_a | input | 64 | First operand (addend, or shuffle bytes 0 to 7) |
| opnd_b | input | 64 | Second operand (addend, or shuffle bytes 8 to 15) |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | 64 | Sum or shuffled result, held between strobes |
| status_q | output | 64 | Status register; the mask is in bits [63:32] |

## Verification
Shuffles are tried with several masks against operands whose bytes all differ:
- The identity mask, which can be told apart from the all-second-operand mask.
- A fully reversed mask, which shows whether the nibble order and the byte order agree.
- The all-zero mask, which replicates one byte into every lane.
- An alternating mask, which mixes both operands in one result.

Each mask is built by a mask operation whose addends are chosen to carry across bit 32 or wrap past bit 63, so that both the sum and the slice that is stored get exercised. Back-to-back masks followed at once by a shuffle tell forwarding of the youngest mask apart from reading the stale register. A shuffle issued after an idle gap shows that the stored value is used.

// File: rtl/bsu_pkg.sv
`timescale 1ns/1ps
package bsu_pkg;

   localparam int OPC_W = 9;
   localparam logic [OPC_W-1:0] OPC_MASK = 9'h019;
   localparam logic [OPC_W-1:0] OPC_SHUF = 9'h04C;

   typedef enum logic [1:0] {
      K_NONE = 2'd0,
      K_MASK = 2'd1,
      K_SHUF = 2'd2
   } op_kind_t;

   function automatic op_kind_t decode_op(input logic vld, input logic [OPC_W-1:0] opc);
      op_kind_t k;
      k = K_NONE;
      if (vld) begin
         if (opc == OPC_MASK)      k = K_MASK;
         else if (opc == OPC_SHUF) k = K_SHUF;
      end
      return k;
   endfunction

endpackage

// File: rtl/bsu_adder.sv
`timescale 1ns/1ps
module bsu_adder #(
   parameter int DATA_W = 64,
   parameter int SPLIT  = 0
) (
   input  logic [DATA_W-1:0] add_x,
   input  logic [DATA_W-1:0] add_y,
   output logic [DATA_W-1:0] add_sum
);

   localparam int LO_W = DATA_W / 2;
   localparam int HI_W = DATA_W - LO_W;

   generate
      if (SPLIT != 0 && SPLIT != 1) begin : g_bad_split
         $error("bsu_adder: SPLIT must be 0 or 1");
      end

      if (SPLIT == 1) begin : g_split
         logic [LO_W:0]   lo_part;
         logic [HI_W-1:0] hi_part;
         always_comb begin
            lo_part = {1'b0, add_x[LO_W-1:0]} + {1'b0, add_y[LO_W-1:0]};
            hi_part = add_x[DATA_W-1:LO_W] + add_y[DATA_W-1:LO_W]
                    + {{(HI_W-1){1'b0}}, lo_part[LO_W]};
         end
         assign add_sum = {hi_part, lo_part[LO_W-1:0]};
      end else begin : g_flat
         assign add_sum = add_x + add_y;
      end
   endgenerate

endmodule

// File: rtl/bsu_lane_select.sv
`timescale 1ns/1ps
module bsu_lane_select #(
   parameter int DATA_W = 64,
   parameter int LANE_W = 8
) (
   input  logic [DATA_W-1:0]                           src_a,
   input  logic [DATA_W-1:0]                           src_b,
   input  logic [(DATA_W/LANE_W)*$clog2(2*(DATA_W/LANE_W))-1:0] sel_mask,
   output logic [DATA_W-1:0]                           lanes_out
);

   localparam int LANES = DATA_W / LANE_W;
   localparam int SEL_W = $clog2(2 * LANES);
   localparam int POOL  = 2 * LANES;

   logic [LANE_W-1:0] pool_bytes [POOL];

   generate
      for (genvar p = 0; p < LANES; p++) begin : g_pool
         assign pool_bytes[p]         = src_a[p*LANE_W +: LANE_W];
         assign pool_bytes[p + LANES] = src_b[p*LANE_W +: LANE_W];
      end

      for (genvar i = 0; i < LANES; i++) begin : g_lane
         logic [SEL_W-1:0] pick;
         assign pick = sel_mask[i*SEL_W +: SEL_W];
         assign lanes_out[i*LANE_W +: LANE_W] = pool_bytes[pick];
      end
   endgenerate

endmodule

// File: rtl/bsu_status_reg.sv
`timescale 1ns/1ps
module bsu_status_reg #(
   parameter int DATA_W = 64,
   parameter int MASK_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [MASK_W-1:0] wr_mask,
   output logic [DATA_W-1:0] status_q,
   output logic [MASK_W-1:0] mask_eff
);

   localparam int FIELD_LO = DATA_W - MASK_W;

   logic [DATA_W-1:0] stat_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_r <= '0;
      end else if (wr_en) begin
         stat_r[DATA_W-1:FIELD_LO] <= wr_mask;
      end
   end

   // forward a mask that is still on its way to the register
   assign mask_eff = wr_en ? wr_mask : stat_r[DATA_W-1:FIELD_LO];
   assign status_q = stat_r;

endmodule

// File: rtl/byte_steer_unit.sv
`timescale 1ns/1ps
module byte_steer_unit
   import bsu_pkg::*;
#(
   parameter int DATA_W    = 64,
   parameter int LANE_W    = 8,
   parameter int ADD_SPLIT = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [8:0]        op_code,
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   output logic              res_valid,
   output logic [DATA_W-1:0] res_data,
   output logic [DATA_W-1:0] status_q
);

   localparam int LANES  = DATA_W / LANE_W;
   localparam int SEL_W  = $clog2(2 * LANES);
   localparam int MASK_W = LANES * SEL_W;

   generate
      if (DATA_W % LANE_W != 0) begin : g_bad_lane
         $error("byte_steer_unit: DATA_W must be a multiple of LANE_W");
      end
      if (LANES < 2) begin : g_bad_count
         $error("byte_steer_unit: at least two lanes are required");
      end
      if (2 * MASK_W > DATA_W) begin : g_bad_mask
         $error("byte_steer_unit: mask must fit in the upper half of the status register");
      end
      if (OPC_W != 9) begin : g_bad_opc
         $error("byte_steer_unit: opcode width mismatch with package");
      end
   endgenerate

   // ---------------- stage 1: capture ----------------
   op_kind_t          s1_kind;
   logic [DATA_W-1:0] s1_a;
   logic [DATA_W-1:0] s1_b;
   op_kind_t          in_kind;

   assign in_kind = decode_op(op_valid, op_code);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_kind <= K_NONE;
         s1_a    <= '0;
         s1_b    <= '0;
      end else begin
         s1_kind <= in_kind;
         if (in_kind != K_NONE) begin
            s1_a <= opnd_a;
            s1_b <= opnd_b;
         end
      end
   end

   // ---------------- stage 1 -> 2: compute ----------------
   op_kind_t          s2_kind;
   logic [DATA_W-1:0] s2_data;
   logic [DATA_W-1:0] sum_w;
   logic [DATA_W-1:0] shuf_w;
   logic [MASK_W-1:0] mask_now;
   logic              mask_wr;

   bsu_adder #(
      .DATA_W (DATA_W),
      .SPLIT  (ADD_SPLIT)
   ) u_add (
      .add_x   (s1_a),
      .add_y   (s1_b),
      .add_sum (sum_w)
   );

   bsu_lane_select #(
      .DATA_W (DATA_W),
      .LANE_W (LANE_W)
   ) u_sel (
      .src_a     (s1_a),
      .src_b     (s1_b),
      .sel_mask  (mask_now),
      .lanes_out (shuf_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s2_kind <= K_NONE;
         s2_data <= '0;
      end else begin
         s2_kind <= s1_kind;
         if (s1_kind == K_MASK)      s2_data <= sum_w;
         else if (s1_kind == K_SHUF) s2_data <= shuf_w;
      end
   end

   // ---------------- write-back of the mask ----------------
   assign mask_wr = (s2_kind == K_MASK);

   bsu_status_reg #(
      .DATA_W (DATA_W),
      .MASK_W (MASK_W)
   ) u_stat (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (mask_wr),
      .wr_mask  (s2_data[MASK_W-1:0]),
      .status_q (status_q),
      .mask_eff (mask_now)
   );

   assign res_valid = (s2_kind != K_NONE);
   assign res_data  = s2_data;

endmodule

// File: rtl/bsu_checker.sv
`timescale 1ns/1ps
module bsu_checker
   import bsu_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int MASK_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              op_valid,
   input logic [8:0]        op_code,
   input logic [DATA_W-1:0] opnd_a,
   input logic [DATA_W-1:0] opnd_b,
   input logic              res_valid,
   input logic [DATA_W-1:0] res_data,
   input logic [DATA_W-1:0] status_q
);

   localparam int FIELD_LO = DATA_W - MASK_W;

   logic [1:0] age;
   logic       known;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         age <= 2'd0;
      else if (age != 2'd3) age <= age + 2'd1;
   end

   assign known = op_valid && (op_code == OPC_MASK || op_code == OPC_SHUF);

   AST_RES_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2'd2) |-> (res_valid == $past(known, 2)));                         // R1

   AST_MASK_SUM: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2'd2 && res_valid && $past(op_code, 2) == OPC_MASK)
      |-> (res_data == $past(opnd_a, 2) + $past(opnd_b, 2)));                    // R2

   AST_MASK_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd3 && $past(res_valid) && $past(op_code, 3) == OPC_MASK)
      |-> (status_q[DATA_W-1:FIELD_LO] == $past(res_data[MASK_W-1:0])));        // R3

   AST_STATUS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2'd1) |-> $stable(status_q[FIELD_LO-1:0]));                        // R3

   AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd3 && !($past(res_valid) && $past(op_code, 3) == OPC_MASK))
      |-> $stable(status_q));                                                    // R9

endmodule

bind byte_steer_unit bsu_checker #(
   .DATA_W (DATA_W),
   .MASK_W (MASK_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .op_valid  (op_valid),
   .op_code   (op_code),
   .opnd_a    (opnd_a),
   .opnd_b    (opnd_b),
   .res_valid (res_valid),
   .res_data  (res_data),
   .status_q  (status_q)
);

// File: tb/sim_byte_steer_unit.sv
`timescale 1ns/1ps
module sim_byte_steer_unit;

   localparam logic [8:0] OP_MASK = 9'h019;
   localparam logic [8:0] OP_SHUF = 9'h04C;
   localparam int         NVEC    = 6;
   localparam logic [63:0] SH_A = 64'h8786_8584_8382_8180;
   localparam logic [63:0] SH_B = 64'h9796_9594_9392_9190;
   localparam logic [63:0] A2   = 64'h0706_0504_0302_0100;
   localparam logic [63:0] B2   = 64'h0F0E_0D0C_0B0A_0908;

   // fields: mask addend x, mask addend y, expected sum, expected shuffle of SH_A/SH_B
   localparam logic [255:0] VEC [NVEC] = '{
      {64'h0000_0000_7654_3200, 64'h0000_0000_0000_0010, 64'h0000_0000_7654_3210, 64'h8786_8584_8382_8180},
      {64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_FEDC_BA99, 64'h0000_0000_FEDC_BA98, 64'h9796_9594_9392_9190},
      {64'h1234_5678_0000_0000, 64'h0000_0000_0123_4567, 64'h1234_5678_0123_4567, 64'h8081_8283_8485_8687},
      {64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001, 64'h0000_0001_0000_0000, 64'h8080_8080_8080_8080},
      {64'h8000_0000_F0F0_0000, 64'h8000_0000_0000_F0F0, 64'h0000_0000_F0F0_F0F0, 64'h9780_9780_9780_9780},
      {64'hAAAA_AAAA_89AB_CDEF, 64'h0000_0000_0000_0000, 64'hAAAA_AAAA_89AB_CDEF, 64'h9091_9293_9495_9697}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [8:0]  op_code = '0;
   logic [63:0] opnd_a = '0;
   logic [63:0] opnd_b = '0;
   logic        res_valid;
   logic [63:0] res_data;
   logic [63:0] status_q;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   byte_steer_unit u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .op_valid  (op_valid),
      .op_code   (op_code),
      .opnd_a    (opnd_a),
      .opnd_b    (opnd_b),
      .res_valid (res_valid),
      .res_data  (res_data),
      .status_q  (status_q)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic issue(input logic v, input logic [8:0] opc, input logic [63:0] a, input logic [63:0] b);
      @(negedge clk);
      op_valid = v;
      op_code  = opc;
      opnd_a   = a;
      opnd_b   = b;
   endtask

   task automatic idle();
      @(negedge clk);
      op_valid = 1'b0;
      op_code  = '0;
      opnd_a   = '0;
      opnd_b   = '0;
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(8 * 200000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      logic [63:0] g_before;
      repeat (3) @(negedge clk);
      // R10: values held in reset
      check("R10 status in reset", status_q, 64'h0);
      check("R10 res_valid in reset", {63'h0, res_valid}, 64'h0);
      check("R10 res_data in reset", res_data, 64'h0);
      rst_n = 1'b1;
      repeat (2) idle();

      // table walk: mask, then shuffle in the next cycle (forwarded mask)
      for (int k = 0; k < NVEC; k++) begin
         logic [63:0] vx, vy, vsum, vshuf;
         {vx, vy, vsum, vshuf} = VEC[k];
         issue(1'b1, OP_MASK, vx, vy);
         issue(1'b1, OP_SHUF, SH_A, SH_B);
         idle();
         check("R1 mask res_valid", {63'h0, res_valid}, 64'h1);
         check("R2 mask sum", res_data, vsum);
         idle();
         check("R4 R5 R6 R7 shuffle result", res_data, vshuf);
         check("R3 mask stored in status", status_q, {vsum[31:0], 32'h0});
         idle();
         check("R1 res_valid single pulse", {63'h0, res_valid}, 64'h0);
      end

      // R9: invalid strobe and unknown opcodes
      g_before = status_q;
      issue(1'b0, OP_MASK, 64'h1, 64'h2);
      issue(1'b1, 9'h000, 64'h3, 64'h4);
      issue(1'b1, 9'h1FF, 64'h5, 64'h6);
      for (int c = 0; c < 4; c++) begin
         idle();
         check("R9 no res_valid for ignored ops", {63'h0, res_valid}, 64'h0);
         check("R9 status unchanged by ignored ops", status_q, g_before);
      end

      // R8: stored mask (reversed) used after an idle gap
      issue(1'b1, OP_SHUF, A2, B2);
      idle();
      idle();
      check("R8 R6 shuffle with stored mask", res_data, 64'h0809_0A0B_0C0D_0E0F);
      check("R8 shuffle leaves status", status_q, g_before);

      // R7: two masks back to back, then a shuffle at once
      idle();
      issue(1'b1, OP_MASK, 64'h0, 64'h0);
      issue(1'b1, OP_MASK, 64'h0000_0000_7654_3210, 64'h0);
      issue(1'b1, OP_SHUF, A2, B2);
      check("R2 first mask sum", res_data, 64'h0);
      idle();
      check("R2 second mask sum", res_data, 64'h0000_0000_7654_3210);
      check("R3 first mask stored", status_q, 64'h0);
      idle();
      check("R7 shuffle uses younger mask", res_data, A2);
      check("R3 second mask stored", status_q, 64'h7654_3210_0000_0000);

      // R10: reset in the middle of operation
      issue(1'b1, OP_MASK, 64'h0000_0000_1111_1111, 64'h0);
      rst_n = 1'b0;
      op_valid = 1'b0;
      @(negedge clk);
      check("R10 status cleared by reset", status_q, 64'h0);
      check("R10 res_valid cleared by reset", {63'h0, res_valid}, 64'h0);
      rst_n = 1'b1;
      repeat (2) idle();

      finish_run();
   end

endmodule